// File: doc/BRIEF.md
# PCI Target Command Decoder

This block is the front end of a simple PCI target. It watches the address phase, latches the command and the address, and decides whether to claim the transaction. A claimed transaction gets medium-speed DEVSEL. It then waits for the single data phase and completes it in one of three ways: TRDY after the work is done, TRDY at once for an empty data phase, or a target abort. Commands outside a small accepted set are never claimed.

I/O space exposes two 32-bit locations. The first is an address register. The second is a data port, and any access to it is passed on to the register bus at the address held in the first. Memory reads, memory writes and configuration reads go to that register bus directly. The bus is a request/ready interface. The request stays up until the back end signals ready, so the wait states follow back-end latency.

The PCI address/data bus is split into separate input, output and output-enable signals. Only one data phase per transaction is handled. The master is expected to release FRAME and IRDY after completion before it starts another cycle.

Top module: `pci_tgt_decoder`

## Requirements
- R1: After reset, devsel_n, trdy_n and stop_n are high, be_req is low, and the indirect address register holds zero.
- R2: Only command codes 0010 (I/O read), 0011 (I/O write), 0110 (memory read), 0111 (memory write) and 1010 (configuration read) are claimed. Every other code leaves devsel_n, trdy_n and stop_n high and makes no back-end request.
- R3: I/O commands are claimed only when address bits [31:3] equal those of IO_BASE. Memory commands are claimed only when bits [31:MEM_AW] equal those of MEM_BASE. A configuration read is claimed only when idsel is high in the address phase. Anything else is not claimed.
- R4: For a claimed cycle, devsel_n goes low at the second rising edge after the edge that first sees frame_n low.
- R5: An I/O access with address bit 2 clear reaches the indirect address register. A write updates only the bytes whose active-low enables are 0 (cbe_n bit i selects bits 8i+7..8i). A read returns all 32 bits. Neither makes a back-end request.
- R6: An I/O access with address bit 2 set becomes a back-end request at {indirect[31:2],2'b00}. It is a write for 0011 and a read for 0010. be_wstrb is the inverse of the data-phase cbe_n.
- R7: For any I/O access, the index of the lowest enabled byte lane (0..3) must equal address bits [1:0]. Otherwise the cycle ends in a target abort.
- R8: For I/O and memory cycles, the accepted active-low byte-enable patterns are 1110, 1101, 1011, 0111, 1100, 0011 and 0000. Any other non-empty pattern ends in a target abort, and neither a back-end request nor a register update takes place.
- R9: A target abort drives stop_n low while devsel_n and trdy_n are high, and trdy_n and stop_n are never low together.
- R10: A data phase with cbe_n = 1111 completes with trdy_n low at the first edge after the edge that sees irdy_n low. No back-end request is made.
- R11: A configuration read issues a back-end read with be_cfg high and be_wstrb = 1111 whatever the byte enables are, including patterns refused under R8. The full 32-bit result is returned on ad_out.
- R12: A back-end request holds its address until be_ready is sampled high. trdy_n goes low at the following edge, and read data appears on ad_out with ad_oe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Cycle frame from the master, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration select for this device |
| cbe_n | input | 4 | Command in the address phase, byte enables in the data phase |
| ad_in | input | 32 | Address/data bus as seen by the target |
| ad_out | output | 32 | Read data driven to the bus |
| ad_oe | output | 1 | Read data valid on ad_out |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop (target abort), active low |
| be_req | output | 1 | Back-end request |
| be_we | output | 1 | Back-end write (1) or read (0) |
| be_cfg | output | 1 | Request targets configuration space |
| be_addr | output | 32 | Dword-aligned back-end address |
| be_wdata | output | 32 | Back-end write data |
| be_wstrb | output | 4 | Back-end byte strobes, active high |
| be_ready | input | 1 | Back end accepts or finishes the request |
| be_rdata | input | 32 | Back-end read data, valid with be_ready |

## Verification
The properties assume a cooperative master. frame_n is high for exactly the one cycle after the address phase. irdy_n stays low from then until the target answers. Both lines return high before the next frame_n fall. The bench stimulus is built by one transaction task that keeps to that order, and it releases irdy_n only after an answer or after a bounded wait on an unclaimed cycle. The back end is assumed to raise be_ready only while be_req is high and to drop it once the request goes away. The bench model does this, and it draws a latency between zero and four cycles for each transfer.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  typedef enum logic [2:0] {
    K_NONE   = 3'd0,
    K_IOADDR = 3'd1,
    K_IODATA = 3'd2,
    K_MEM    = 3'd3,
    K_CFG    = 3'd4
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DEC  = 3'd1,
    ST_DATA = 3'd2,
    ST_BUSY = 3'd3,
    ST_DONE = 3'd4,
    ST_REL  = 3'd5
  } state_e;

  localparam logic [3:0] CMD_IORD = 4'b0010;
  localparam logic [3:0] CMD_IOWR = 4'b0011;
  localparam logic [3:0] CMD_MRD  = 4'b0110;
  localparam logic [3:0] CMD_MWR  = 4'b0111;
  localparam logic [3:0] CMD_CRD  = 4'b1010;

  // accepted active-low enable patterns: one byte, an aligned half, or all four
  function automatic logic be_pattern_ok(input logic [3:0] be_n);
    case (be_n)
      4'b1110, 4'b1101, 4'b1011, 4'b0111,
      4'b1100, 4'b0011, 4'b0000: be_pattern_ok = 1'b1;
      default:                   be_pattern_ok = 1'b0;
    endcase
  endfunction

  // index of the lowest enabled lane
  function automatic logic [1:0] lowest_lane(input logic [3:0] be_n);
    if (!be_n[0])      lowest_lane = 2'd0;
    else if (!be_n[1]) lowest_lane = 2'd1;
    else if (!be_n[2]) lowest_lane = 2'd2;
    else               lowest_lane = 2'd3;
  endfunction

endpackage

// File: rtl/pci_tgt_addr_decode.sv
module pci_tgt_addr_decode
  import pci_tgt_pkg::*;
#(
  parameter logic [31:0] IO_BASE  = 32'h0000_1000,
  parameter logic [31:0] MEM_BASE = 32'h8000_0000,
  parameter int          MEM_AW   = 12
) (
  input  logic [3:0]  cmd,
  input  logic [31:2] addr,
  input  logic        sel,
  output logic        claim,
  output kind_e       kind,
  output logic        is_write
);

  logic io_hit;
  logic mem_hit;

  assign io_hit  = (addr[31:3] == IO_BASE[31:3]);
  assign mem_hit = (addr[31:MEM_AW] == MEM_BASE[31:MEM_AW]);

  always_comb begin
    kind     = K_NONE;
    is_write = 1'b0;
    case (cmd)
      CMD_IORD, CMD_IOWR: begin
        if (io_hit) kind = addr[2] ? K_IODATA : K_IOADDR;
        is_write = cmd[0];
      end
      CMD_MRD, CMD_MWR: begin
        if (mem_hit) kind = K_MEM;
        is_write = cmd[0];
      end
      CMD_CRD: begin
        if (sel) kind = K_CFG;
      end
      default: kind = K_NONE;
    endcase
    claim = (kind != K_NONE);
  end

endmodule

// File: rtl/pci_tgt_be_check.sv
module pci_tgt_be_check
  import pci_tgt_pkg::*;
(
  input  kind_e      kind,
  input  logic [1:0] addr_lo,
  input  logic [3:0] be_n,
  output logic       nop,
  output logic       abort
);

  logic is_io;
  logic lane_bad;

  assign is_io    = (kind == K_IOADDR) || (kind == K_IODATA);
  assign lane_bad = is_io && (lowest_lane(be_n) != addr_lo);
  assign nop      = &be_n;
  assign abort    = !nop && (kind != K_CFG) && (!be_pattern_ok(be_n) || lane_bad);

endmodule

// File: rtl/pci_tgt_ind_reg.sv
module pci_tgt_ind_reg #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [W/8-1:0] wstrb,
  input  logic [W-1:0]   wdata,
  output logic [W-1:0]   q
);

  localparam int NL = W / 8;

  logic [7:0] lane_q [NL];

  for (genvar i = 0; i < NL; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)                      lane_q[i] <= 8'h00;
      else if (wr_en && wstrb[i])   lane_q[i] <= wdata[i*8 +: 8];
    end
    assign q[i*8 +: 8] = lane_q[i];
  end

endmodule

// File: rtl/pci_tgt_decoder.sv
module pci_tgt_decoder
  import pci_tgt_pkg::*;
#(
  parameter logic [31:0] IO_BASE  = 32'h0000_1000,
  parameter logic [31:0] MEM_BASE = 32'h8000_0000,
  parameter int          MEM_AW   = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        idsel,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad_in,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        stop_n,
  output logic        be_req,
  output logic        be_we,
  output logic        be_cfg,
  output logic [31:0] be_addr,
  output logic [31:0] be_wdata,
  output logic [3:0]  be_wstrb,
  input  logic        be_ready,
  input  logic [31:0] be_rdata
);

  state_e      state;
  logic [3:0]  cmd_q;
  logic [31:0] addr_q;
  logic        sel_q;
  kind_e       kind_q;
  logic        wr_q;

  logic        dec_claim;
  kind_e       dec_kind;
  logic        dec_wr;
  logic        ph_nop;
  logic        ph_abort;
  logic [31:0] ind_q;
  logic        ind_wr;

  pci_tgt_addr_decode #(
    .IO_BASE (IO_BASE),
    .MEM_BASE(MEM_BASE),
    .MEM_AW  (MEM_AW)
  ) u_dec (
    .cmd     (cmd_q),
    .addr    (addr_q[31:2]),
    .sel     (sel_q),
    .claim   (dec_claim),
    .kind    (dec_kind),
    .is_write(dec_wr)
  );

  pci_tgt_be_check u_bechk (
    .kind   (kind_q),
    .addr_lo(addr_q[1:0]),
    .be_n   (cbe_n),
    .nop    (ph_nop),
    .abort  (ph_abort)
  );

  assign ind_wr = (state == ST_DATA) && !irdy_n && (kind_q == K_IOADDR) &&
                  wr_q && !ph_nop && !ph_abort;

  pci_tgt_ind_reg #(.W(32)) u_ind (
    .clk  (clk),
    .rst  (rst),
    .wr_en(ind_wr),
    .wstrb(~cbe_n),
    .wdata(ad_in),
    .q    (ind_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cmd_q    <= 4'h0;
      addr_q   <= 32'h0;
      sel_q    <= 1'b0;
      kind_q   <= K_NONE;
      wr_q     <= 1'b0;
      ad_out   <= 32'h0;
      ad_oe    <= 1'b0;
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      stop_n   <= 1'b1;
      be_req   <= 1'b0;
      be_we    <= 1'b0;
      be_cfg   <= 1'b0;
      be_addr  <= 32'h0;
      be_wdata <= 32'h0;
      be_wstrb <= 4'h0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!frame_n) begin
            cmd_q  <= cbe_n;
            addr_q <= ad_in;
            sel_q  <= idsel;
            state  <= ST_DEC;
          end
        end
        ST_DEC: begin
          if (dec_claim) begin
            devsel_n <= 1'b0;
            kind_q   <= dec_kind;
            wr_q     <= dec_wr;
            state    <= ST_DATA;
          end else begin
            state    <= ST_REL;
          end
        end
        ST_DATA: begin
          if (!irdy_n) begin
            if (ph_nop) begin
              trdy_n <= 1'b0;
              state  <= ST_DONE;
            end else if (ph_abort) begin
              devsel_n <= 1'b1;
              stop_n   <= 1'b0;
              state    <= ST_DONE;
            end else if (kind_q == K_IOADDR) begin
              trdy_n <= 1'b0;
              if (!wr_q) begin
                ad_out <= ind_q;
                ad_oe  <= 1'b1;
              end
              state  <= ST_DONE;
            end else begin
              be_req   <= 1'b1;
              be_we    <= wr_q;
              be_cfg   <= (kind_q == K_CFG);
              be_addr  <= (kind_q == K_IODATA) ? {ind_q[31:2], 2'b00}
                                               : {addr_q[31:2], 2'b00};
              be_wdata <= ad_in;
              be_wstrb <= (kind_q == K_CFG) ? 4'hF : ~cbe_n;
              state    <= ST_BUSY;
            end
          end
        end
        ST_BUSY: begin
          if (be_ready) begin
            be_req <= 1'b0;
            trdy_n <= 1'b0;
            if (!be_we) begin
              ad_out <= be_rdata;
              ad_oe  <= 1'b1;
            end
            state  <= ST_DONE;
          end
        end
        ST_DONE: begin
          trdy_n   <= 1'b1;
          stop_n   <= 1'b1;
          devsel_n <= 1'b1;
          ad_oe    <= 1'b0;
          state    <= ST_REL;
        end
        ST_REL: begin
          if (frame_n && irdy_n) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pci_tgt_decoder_chk.sv
module pci_tgt_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic        frame_n,
  input logic        devsel_n,
  input logic        trdy_n,
  input logic        stop_n,
  input logic        be_req,
  input logic        be_we,
  input logic        be_cfg,
  input logic [31:0] be_addr,
  input logic [3:0]  be_wstrb,
  input logic        be_ready
);

  a_r4_devsel_medium: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_n) |-> !$past(frame_n, 2));

  a_r9_abort_shape: assert property (@(posedge clk) disable iff (rst)
    !stop_n |-> (devsel_n && trdy_n && !be_req));

  a_r11_cfg_full: assert property (@(posedge clk) disable iff (rst)
    (be_req && be_cfg) |-> (!be_we && be_wstrb == 4'hF));

  a_r12_hold_req: assert property (@(posedge clk) disable iff (rst)
    (be_req && !be_ready) |=> (be_req && $stable(be_addr) && trdy_n));

  a_r12_ready_done: assert property (@(posedge clk) disable iff (rst)
    (be_req && be_ready) |=> (!trdy_n && !be_req));

endmodule

bind pci_tgt_decoder pci_tgt_decoder_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .frame_n (frame_n),
  .devsel_n(devsel_n),
  .trdy_n  (trdy_n),
  .stop_n  (stop_n),
  .be_req  (be_req),
  .be_we   (be_we),
  .be_cfg  (be_cfg),
  .be_addr (be_addr),
  .be_wstrb(be_wstrb),
  .be_ready(be_ready)
);

// File: tb/tb_pci_tgt_decoder.sv
module tb_pci_tgt_decoder;

  localparam logic [31:0] IOB  = 32'h0000_1000;
  localparam logic [31:0] MEMB = 32'h8000_0000;
  localparam int          MAW  = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_in = 32'h0;
  logic [31:0] ad_out;
  logic        ad_oe, devsel_n, trdy_n, stop_n;
  logic        be_req, be_we, be_cfg;
  logic [31:0] be_addr, be_wdata;
  logic [3:0]  be_wstrb;
  logic        be_ready = 1'b0;
  logic [31:0] be_rdata = 32'h0;

  always #5 clk = ~clk;

  pci_tgt_decoder #(.IO_BASE(IOB), .MEM_BASE(MEMB), .MEM_AW(MAW)) dut (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
    .be_req(be_req), .be_we(be_we), .be_cfg(be_cfg), .be_addr(be_addr),
    .be_wdata(be_wdata), .be_wstrb(be_wstrb), .be_ready(be_ready),
    .be_rdata(be_rdata)
  );

  int checks = 0, failures = 0;
  int xfers = 0, lat = 0, wcnt = 0;
  logic [31:0] mem [16];

  // transaction results
  int          r_res, r_n, r_nx;
  logic        r_dev0, r_oe;
  logic [31:0] r_rd;

  always @(posedge clk) begin
    if (be_req && be_ready) begin
      xfers++;
      if (be_we)
        for (int i = 0; i < 4; i++)
          if (be_wstrb[i]) mem[be_addr[5:2]][i*8 +: 8] = be_wdata[i*8 +: 8];
    end
  end

  always @(negedge clk) begin
    if (!be_req) begin
      be_ready = 1'b0;
      wcnt = 0;
    end else if (!be_ready) begin
      if (wcnt == lat) begin
        be_ready = 1'b1;
        be_rdata = be_cfg ? (32'hCF60_0000 | be_addr) : mem[be_addr[5:2]];
      end else begin
        wcnt++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // res: 0 no answer, 1 TRDY, 2 target abort
  task automatic txn(input logic [3:0] cmd, input logic [31:0] addr,
                     input logic [3:0] be, input logic [31:0] wd, input logic sel);
    int x0;
    x0 = xfers;
    @(negedge clk);
    frame_n = 1'b0; cbe_n = cmd; ad_in = addr; idsel = sel;
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b0; cbe_n = be; ad_in = wd; idsel = 1'b0;
    @(negedge clk);
    r_dev0 = devsel_n;
    r_n = 1;
    while (trdy_n && stop_n && r_n < 16) begin
      @(negedge clk);
      r_n++;
    end
    r_oe = ad_oe;
    r_rd = ad_out;
    if (!trdy_n)      r_res = 1;
    else if (!stop_n) r_res = (devsel_n && trdy_n) ? 2 : 3;
    else              r_res = 0;
    irdy_n = 1'b1; cbe_n = 4'hF;
    repeat (2) @(negedge clk);
    r_nx = xfers - x0;
  endtask

  function automatic logic be_good(input logic [3:0] b);
    int z;
    z = 0;
    for (int i = 0; i < 4; i++) z += (b[i] == 1'b0) ? 1 : 0;
    return (z == 1) || (b == 4'h0) || (b == 4'h3) || (b == 4'hC);
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] b);
    logic [31:0] r;
    r = o;
    for (int i = 0; i < 4; i++) if (!b[i]) r[i*8 +: 8] = n[i*8 +: 8];
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired got=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] e;
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 devsel_n", {31'h0, devsel_n}, 32'h1);
    chk("R1 trdy_n", {31'h0, trdy_n}, 32'h1);
    chk("R1 stop_n", {31'h0, stop_n}, 32'h1);
    chk("R1 be_req", {31'h0, be_req}, 32'h0);
    txn(4'b0010, IOB, 4'h0, 32'h0, 1'b0);
    chk("R1 indirect zero", r_rd, 32'h0);

    // R2 unclaimed command codes
    for (int c = 0; c < 16; c++) begin
      if (c == 2 || c == 3 || c == 6 || c == 7 || c == 10) continue;
      txn(c[3:0], MEMB + 32'h10, 4'h0, 32'h1234_5678, 1'b1);
      chk("R2 no devsel", {31'h0, r_dev0}, 32'h1);
      chk("R2 no answer", r_res, 0);
      chk("R2 no backend", r_nx, 0);
    end

    // R3 windows
    txn(4'b0011, IOB + 32'h8, 4'h0, 32'h5, 1'b0);
    chk("R3 io outside", r_res + 10 * r_nx, 0);
    txn(4'b0110, MEMB + (32'h1 << MAW), 4'h0, 32'h0, 1'b0);
    chk("R3 mem outside", r_res + 10 * r_nx, 0);
    txn(4'b1010, 32'h0, 4'h0, 32'h0, 1'b0);
    chk("R3 cfg no idsel", r_res + 10 * r_nx, 0);

    // R5 address register, R4 timing
    txn(4'b0011, IOB, 4'h0, 32'h0000_0010, 1'b0);
    chk("R4 devsel medium", {31'h0, r_dev0}, 32'h0);
    chk("R5 full write done", r_res + 10 * r_nx, 1);
    txn(4'b0011, IOB + 32'h1, 4'b1101, 32'h0000_AB00, 1'b0);
    txn(4'b0010, IOB, 4'h0, 32'h0, 1'b0);
    chk("R5 merged readback", r_rd, 32'h0000_AB10);
    chk("R5 read no backend", r_nx, 0);
    txn(4'b0011, IOB + 32'h1, 4'b1101, 32'h0000_0000, 1'b0);
    txn(4'b0010, IOB, 4'h0, 32'h0, 1'b0);
    chk("R5 lane1 cleared", r_rd, 32'h0000_0010);

    // R6 data port into memory word 4
    lat = 1;
    txn(4'b0011, IOB + 32'h4, 4'h0, 32'hDEAD_BEEF, 1'b0);
    chk("R6 write done", r_res + 10 * r_nx, 11);
    chk("R6 memory word", mem[4], 32'hDEAD_BEEF);
    txn(4'b0110, MEMB + 32'h10, 4'h0, 32'h0, 1'b0);
    chk("R6 mem read", r_rd, 32'hDEAD_BEEF);
    mem[4] = 32'h0BAD_F00D;
    txn(4'b0010, IOB + 32'h4, 4'h0, 32'h0, 1'b0);
    chk("R6 port read", r_rd, 32'h0BAD_F00D);
    chk("R6 port read oe", {31'h0, r_oe}, 32'h1);

    // R7 lane consistency on the data port
    txn(4'b0011, IOB + 32'h4, 4'b1101, 32'h0000_7700, 1'b0);
    chk("R7 lane mismatch abort", r_res + 10 * r_nx, 2);
    txn(4'b0011, IOB + 32'h5, 4'b1101, 32'h0000_7700, 1'b0);
    chk("R7 lane match", mem[4], 32'h0BAD_770D);

    // R8, R9, R10 sweep of byte enables on memory write to word 8
    for (int b = 0; b < 16; b++) begin
      lat = b % 3;
      txn(4'b0111, MEMB + 32'h20, 4'h0, 32'h1122_3344, 1'b0);
      txn(4'b0111, MEMB + 32'h20, b[3:0], 32'hA5A5_A5A5, 1'b0);
      if (b == 15) begin
        chk("R10 nop answer", r_res, 1);
        chk("R10 nop timing", r_n, 2);
        chk("R10 nop no backend", r_nx, 0);
        e = 32'h1122_3344;
      end else if (be_good(b[3:0])) begin
        chk("R8 accepted", r_res + 10 * r_nx, 11);
        e = merge(32'h1122_3344, 32'hA5A5_A5A5, b[3:0]);
      end else begin
        chk("R9 abort shape", r_res, 2);
        chk("R8 no backend", r_nx, 0);
        e = 32'h1122_3344;
      end
      chk("R8 memory word", mem[8], e);
    end
    // R8 refused pattern on the address register leaves it unchanged
    txn(4'b0011, IOB, 4'b1010, 32'hFFFF_FFFF, 1'b0);
    chk("R9 io abort", r_res, 2);
    txn(4'b0010, IOB, 4'h0, 32'h0, 1'b0);
    chk("R8 register kept", r_rd, 32'h0000_0010);
    // R10 nop on I/O read
    txn(4'b0010, IOB, 4'hF, 32'h0, 1'b0);
    chk("R10 io nop", r_res + 10 * r_nx + 100 * r_n, 201);

    // R11 configuration read ignores enables
    lat = 2;
    txn(4'b1010, 32'h0000_0008, 4'b0101, 32'h0, 1'b1);
    chk("R11 cfg data", r_rd, 32'hCF60_0008);
    chk("R11 cfg completes", r_res + 10 * r_nx, 11);

    // R12 wait states follow back-end latency
    for (int l = 0; l < 5; l++) begin
      lat = l;
      txn(4'b0110, MEMB + 32'h20, 4'h0, 32'h0, 1'b0);
      chk("R12 trdy after ready", r_n, 3 + l);
      chk("R12 read data", r_rd, 32'h1122_3344);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule